// File: doc/BRIEF.md
# Mini UART register and interrupt block

This block is the 32-bit memory-mapped register front end of a simplified UART. Received bytes come in on a valid/ready byte interface and land in a small circular receive FIFO. Software drains that FIFO by reading the data register, controls two interrupt sources through an enable register, finds out why the interrupt line is high from an identification register, and can flush everything queued in the FIFO with a single write. A write to the data register sends its low byte out as a one-cycle transmit strobe. The transmit side is treated as always empty and instantly drained, so an enabled transmit interrupt never drops.

The status registers combine fixed constant bits with the live receive fill level. Offsets that are not implemented read as zero and ignore writes. The bus is single-cycle: read data is driven combinationally during the access cycle, and any side effect of the access (popping, flushing, enable update, transmit) takes effect at the clock edge that closes the cycle. The asynchronous active-low reset is released synchronously through a two-stage synchroniser, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `mu_regblk`

## Requirements
- R1: While in reset and after reset, the FIFO is empty, both enable bits are clear, `irq` and `tx_valid` are low and `rx_ready` is high; the enable register then reads 0xC0.
- R2: A write to offset 0x44 keeps only write-data bits 1 (transmit enable) and 0 (receive enable); a read of 0x44 returns those two bits ORed with 0xC0.
- R3: `irq` is high exactly when the transmit enable is set, or the receive enable is set and the FIFO holds at least one byte; offset 0x00 reads 1 when `irq` is high and 0 otherwise.
- R4: Offset 0x48 reads 0xC0 ORed with 0x4 when the FIFO holds data (0x2 when it is empty), ORed with 0x1 when `irq` is low.
- R5: A write to 0x48 with bit 1 set empties the FIFO without moving the read position and discards a byte offered in the same cycle; with bit 1 clear the write has no effect.
- R6: A read of 0x40 returns, in bits 7:0, the oldest byte in the FIFO and removes it; bytes leave in arrival order, and storage wraps after 8 entries.
- R7: A read of 0x40 when the FIFO is empty returns the byte still held in the slot at the read position and changes neither the position nor the fill level.
- R8: `rx_ready` is high exactly when fewer than 8 bytes are held; a byte offered while the FIFO is full is not stored.
- R9: A byte accepted in the same cycle as a data-register read of a non-empty FIFO leaves the fill level unchanged, and both bytes keep their place in the order.
- R10: Offset 0x54 reads 0x60 with bit 0 set when data is present; offset 0x60 reads 0x3; offset 0x04 reads 0x1.
- R11: Offset 0x64 reads 0x30E when the FIFO is empty; when it holds data, bit 0 is also set and the fill level is placed in bits 19:16.
- R12: A write to 0x40 makes `tx_valid` high for the next cycle with `tx_byte` equal to write-data bits 7:0; `tx_valid` is low in every cycle not preceded by such a write.
- R13: Reads of any other offset, including 0x4C, 0x5C, 0x68 and unaligned addresses, return 0, and writes to them (and to 0x00, 0x04, 0x54, 0x60, 0x64) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset inside the 0x100 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle, zero otherwise |
| rx_valid | input | 1 | Incoming byte offered |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO has space; a byte is taken when valid and ready are both high |
| tx_valid | output | 1 | One-cycle strobe for an outgoing byte |
| tx_byte | output | 8 | Outgoing byte |
| irq | output | 1 | Interrupt request |

## Verification
The FIFO is driven with single bytes, a complete fill followed by an overflow attempt, a full drain followed by one read past empty, and same-cycle receive and pop, which separates the wrap arithmetic, the full gating, the stale-slot read and the count update for concurrent push and pop. Flush is tried alone, with bit 1 clear, and together with an arriving byte, which shows whether flush moves the read position or lets the byte in. Enable values cover all four bit combinations with empty and non-empty FIFOs, so the identification word, the summary bit and the line are seen in every priority case. A long pseudo-random mix of reads, writes, unknown offsets and arrivals then compares every output against a behavioural model on every clock.

// File: rtl/mu_pkg.sv
package mu_pkg;

  // Register offsets (byte addresses inside the 0x100 window)
  localparam int unsigned OFS_SUM   = 'h00;
  localparam int unsigned OFS_ENA   = 'h04;
  localparam int unsigned OFS_DATA  = 'h40;
  localparam int unsigned OFS_IEN   = 'h44;
  localparam int unsigned OFS_IID   = 'h48;
  localparam int unsigned OFS_LSTAT = 'h54;
  localparam int unsigned OFS_XCTL  = 'h60;
  localparam int unsigned OFS_XSTAT = 'h64;

  // Constant parts of read values
  localparam int unsigned RD_FIFO_ON  = 'hC0;
  localparam int unsigned RD_LSTAT    = 'h60;
  localparam int unsigned RD_XCTL     = 'h3;
  localparam int unsigned RD_ENA      = 'h1;
  localparam int unsigned RD_XSTAT    = 'h30E;
  localparam int unsigned XSTAT_FILL_LSB = 16;

  // Enable bit positions
  localparam int unsigned IEN_RX = 0;
  localparam int unsigned IEN_TX = 1;
  // Flush command bit in the identification register
  localparam int unsigned IID_FLUSH = 1;

  typedef enum logic [3:0] {
    RSEL_NONE,
    RSEL_SUM,
    RSEL_ENA,
    RSEL_DATA,
    RSEL_IEN,
    RSEL_IID,
    RSEL_LSTAT,
    RSEL_XCTL,
    RSEL_XSTAT
  } mu_rsel_e;

  typedef struct packed {
    logic data_rd;
    logic data_wr;
    logic ien_wr;
    logic flush;
  } mu_strobe_t;

endpackage

// File: rtl/mu_rst_sync.sv
module mu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/mu_bus_decode.sv
module mu_bus_decode
  import mu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output mu_rsel_e          rsel,
  output mu_strobe_t        strobe
);

  always_comb begin
    rsel   = RSEL_NONE;
    strobe = '0;
    if (bus_sel) begin
      if (bus_addr == ADDR_W'(OFS_SUM))   rsel = RSEL_SUM;
      if (bus_addr == ADDR_W'(OFS_ENA))   rsel = RSEL_ENA;
      if (bus_addr == ADDR_W'(OFS_DATA))  rsel = RSEL_DATA;
      if (bus_addr == ADDR_W'(OFS_IEN))   rsel = RSEL_IEN;
      if (bus_addr == ADDR_W'(OFS_IID))   rsel = RSEL_IID;
      if (bus_addr == ADDR_W'(OFS_LSTAT)) rsel = RSEL_LSTAT;
      if (bus_addr == ADDR_W'(OFS_XCTL))  rsel = RSEL_XCTL;
      if (bus_addr == ADDR_W'(OFS_XSTAT)) rsel = RSEL_XSTAT;
      if (bus_wr) begin
        strobe.data_wr = (rsel == RSEL_DATA);
        strobe.ien_wr  = (rsel == RSEL_IEN);
        strobe.flush   = (rsel == RSEL_IID) && bus_wdata[IID_FLUSH];
        rsel           = RSEL_NONE;
      end else begin
        strobe.data_rd = (rsel == RSEL_DATA);
      end
    end
  end

endmodule

// File: rtl/mu_rx_fifo.sv
module mu_rx_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              pop_req,
  input  logic              flush,
  output logic [BYTE_W-1:0] head_byte,
  output logic [CNT_W-1:0]  fill
);

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PTR_W:0]    slot_sum;
  logic [PTR_W-1:0]  wr_slot;
  logic              push, pop;

  assign in_ready = (cnt_q < CNT_W'(DEPTH));
  assign push     = in_valid && in_ready && !flush;
  assign pop      = pop_req && (cnt_q != '0);

  // Write slot: (read position + count) modulo DEPTH
  assign slot_sum = {1'b0, rd_ptr_q} + {1'b0, cnt_q[PTR_W-1:0]};
  assign wr_slot  = (slot_sum >= (PTR_W+1)'(DEPTH)) ?
                    PTR_W'(slot_sum - (PTR_W+1)'(DEPTH)) : PTR_W'(slot_sum);

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      cnt_d = '0;
    end else begin
      if (pop) begin
        rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage carries no reset; only the write enable gates it
  always_ff @(posedge clk) begin
    if (push) begin
      mem_q[wr_slot] <= in_byte;
    end
  end

  assign head_byte = mem_q[rd_ptr_q];
  assign fill      = cnt_q;

endmodule

// File: rtl/mu_irq_ctrl.sv
module mu_irq_ctrl
  import mu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ien_wr,
  input  logic [1:0] ien_wdata,
  input  logic       rx_has_data,
  output logic [1:0] ien,
  output logic       irq
);

  logic [1:0] ien_q, ien_d;

  always_comb begin
    ien_d = ien_q;
    if (ien_wr) begin
      ien_d = ien_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else begin
      ien_q <= ien_d;
    end
  end

  // Transmit side is always drained, so its source is level-true
  assign irq = ien_q[IEN_TX] || (ien_q[IEN_RX] && rx_has_data);
  assign ien = ien_q;

endmodule

// File: rtl/mu_tx_port.sv
module mu_tx_port #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send,
  input  logic [BYTE_W-1:0] send_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);

  logic              valid_q, valid_d;
  logic [BYTE_W-1:0] byte_q, byte_d;

  always_comb begin
    valid_d = send;
    byte_d  = byte_q;
    if (send) begin
      byte_d = send_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      valid_q <= valid_d;
      byte_q  <= byte_d;
    end
  end

  assign tx_valid = valid_q;
  assign tx_byte  = byte_q;

endmodule

// File: rtl/mu_regblk.sv
module mu_regblk
  import mu_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic              rst_sync_n;
  mu_rsel_e          rsel;
  mu_strobe_t        strobe;
  logic [BYTE_W-1:0] head_byte;
  logic [CNT_W-1:0]  fill;
  logic              has_data;
  logic [1:0]        ier_bits;
  logic [DATA_W-1:0] rdata_d;

  mu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mu_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rsel      (rsel),
    .strobe    (strobe)
  );

  mu_rx_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (rx_valid),
    .in_byte   (rx_byte),
    .in_ready  (rx_ready),
    .pop_req   (strobe.data_rd),
    .flush     (strobe.flush),
    .head_byte (head_byte),
    .fill      (fill)
  );

  assign has_data = (fill != '0);

  mu_irq_ctrl u_irq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ien_wr      (strobe.ien_wr),
    .ien_wdata   (bus_wdata[1:0]),
    .rx_has_data (has_data),
    .ien         (ier_bits),
    .irq         (irq)
  );

  mu_tx_port #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .send      (strobe.data_wr),
    .send_byte (bus_wdata[BYTE_W-1:0]),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );

  // Read multiplexer
  always_comb begin
    rdata_d = '0;
    unique case (rsel)
      RSEL_SUM:   rdata_d = DATA_W'(irq);
      RSEL_ENA:   rdata_d = DATA_W'(RD_ENA);
      RSEL_DATA:  rdata_d = DATA_W'(head_byte);
      RSEL_IEN:   rdata_d = DATA_W'(RD_FIFO_ON) | DATA_W'(ier_bits);
      RSEL_IID:   rdata_d = DATA_W'(RD_FIFO_ON)
                          | (has_data ? DATA_W'(4) : DATA_W'(2))
                          | DATA_W'(!irq);
      RSEL_LSTAT: rdata_d = DATA_W'(RD_LSTAT) | DATA_W'(has_data);
      RSEL_XCTL:  rdata_d = DATA_W'(RD_XCTL);
      RSEL_XSTAT: begin
        rdata_d = DATA_W'(RD_XSTAT);
        if (has_data) begin
          rdata_d = rdata_d | DATA_W'(1) | (DATA_W'(fill) << XSTAT_FILL_LSB);
        end
      end
      default:    rdata_d = '0;
    endcase
  end

  assign bus_rdata = rdata_d;

endmodule

// File: rtl/mu_regblk_chk.sv
module mu_regblk_chk
  import mu_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              irq,
  input logic [CNT_W-1:0]  fill,
  input logic [1:0]        ier
);

  logic is_data_rd, is_data_wr, is_flush;
  assign is_data_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign is_data_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign is_flush   = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_IID))
                      && bus_wdata[IID_FLUSH];

  // R8: never more than DEPTH entries
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    fill <= CNT_W'(DEPTH));

  // R8: a full FIFO stays full when nothing leaves it
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (fill == CNT_W'(DEPTH) && !is_data_rd && !is_flush) |=> fill == CNT_W'(DEPTH));

  // R3: transmit enable forces the line
  p_tx_irq_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ier[1] |-> irq);

  // R3: receive enable with data forces the line
  p_rx_irq_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ier[0] && fill != '0) |-> irq);

  // R3: both disabled keeps the line low
  p_irq_off_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (ier == 2'b00) |-> !irq);

  // R5: flush empties the FIFO
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    is_flush |=> fill == '0);

  // R7: empty read changes nothing
  p_empty_rd_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (is_data_rd && fill == '0 && !rx_valid) |=> fill == '0);

  // R9: push and pop together keep the count
  p_push_pop_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (is_data_rd && fill != '0 && rx_valid && rx_ready) |=> fill == $past(fill));

  // R12: data write yields one strobe with the written byte
  p_tx_strobe_r12: assert property (@(posedge clk) disable iff (!rst_ok_n)
    is_data_wr |=> (tx_valid && tx_byte == $past(bus_wdata[BYTE_W-1:0])));

  // R12: no strobe without a preceding data write
  p_tx_quiet_r12: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !is_data_wr |=> !tx_valid);

endmodule

bind mu_regblk mu_regblk_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_byte   (tx_byte),
  .irq       (irq),
  .fill      (fill),
  .ier       (ier_bits)
);

// File: tb/mu_regblk_tb.sv
module mu_regblk_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  mu_regblk u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  // Behavioural reference model
  logic [7:0] m_mem [8];
  byte unsigned m_q[$];
  int         m_rp;
  bit [1:0]   m_ier;
  bit         m_txv;
  logic [7:0] m_txb;

  function automatic bit m_irq();
    return m_ier[1] || (m_ier[0] && m_q.size() != 0);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] v;
    int n = m_q.size();
    case (a)
      8'h00: v = {31'd0, m_irq()};
      8'h04: v = 32'h1;
      8'h40: v = {24'd0, (n != 0) ? m_q[0] : m_mem[m_rp]};
      8'h44: v = 32'hC0 | {30'd0, m_ier};
      8'h48: v = 32'hC0 | ((n != 0) ? 32'h4 : 32'h2) | {31'd0, !m_irq()};
      8'h54: v = 32'h60 | {31'd0, n != 0};
      8'h60: v = 32'h3;
      8'h64: v = (n != 0) ? (32'h30F | (32'(n) << 16)) : 32'h30E;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus/receive cycle: drive, check, advance model
  task automatic cyc(input bit sel, input bit wr, input logic [7:0] a,
                     input logic [31:0] wd, input bit rv, input logic [7:0] rb,
                     input string tag);
    bit fl, pop, push;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_byte = rb;
    #1;
    check(irq == m_irq(), "R3 irq", {31'd0, irq}, {31'd0, m_irq()});
    check(rx_ready == (m_q.size() < 8), "R8 rx_ready", {31'd0, rx_ready},
          {31'd0, m_q.size() < 8});
    check(tx_valid == m_txv, "R12 tx_valid", {31'd0, tx_valid}, {31'd0, m_txv});
    if (m_txv)
      check(tx_byte == m_txb, "R12 tx_byte", {24'd0, tx_byte}, {24'd0, m_txb});
    if (sel && !wr)
      check(bus_rdata === exp_rd(a), tag, bus_rdata, exp_rd(a));
    // model update for this edge
    fl   = sel && wr && a == 8'h48 && wd[1];
    pop  = sel && !wr && a == 8'h40 && m_q.size() != 0;
    push = rv && m_q.size() < 8 && !fl;
    m_txv = sel && wr && a == 8'h40;
    if (m_txv) m_txb = wd[7:0];
    if (sel && wr && a == 8'h44) m_ier = wd[1:0];
    if (fl) begin
      m_q.delete();
    end else begin
      if (push) begin
        m_mem[(m_rp + m_q.size()) % 8] = rb;
        m_q.push_back(rb);
      end
      if (pop) begin
        void'(m_q.pop_front());
        m_rp = (m_rp + 1) % 8;
      end
    end
    @(posedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, 8'h00, tag);
  endtask
  task automatic rd_reg(input logic [7:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h00, tag);
  endtask
  task automatic give(input logic [7:0] b);
    cyc(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, b, "R8 rx");
  endtask
  task automatic idle();
    cyc(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 8'h00, "idle");
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_rp = 0; m_ier = 2'b00; m_txv = 1'b0; m_txb = 8'h00;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_byte = 0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    // R1: outputs while in reset
    check(irq == 1'b0, "R1 irq in reset", {31'd0, irq}, 32'd0);
    check(tx_valid == 1'b0, "R1 tx_valid in reset", {31'd0, tx_valid}, 32'd0);
    check(rx_ready == 1'b1, "R1 rx_ready in reset", {31'd0, rx_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();

    // R1 / R11 / R4 / R10 after reset
    rd_reg(8'h44, "R1 enable after reset");
    rd_reg(8'h64, "R11 empty ext status");
    rd_reg(8'h48, "R4 id idle");
    rd_reg(8'h54, "R10 line status empty");
    rd_reg(8'h00, "R3 summary low");

    // R2 / R4: enable masks and identification
    wr_reg(8'h44, 32'hFFFF_FFFF, "R2");
    rd_reg(8'h44, "R2 enable readback");
    rd_reg(8'h48, "R4 id tx only");
    rd_reg(8'h00, "R3 summary high");
    wr_reg(8'h44, 32'h0000_0001, "R2");
    rd_reg(8'h44, "R2 rx only readback");

    // R6 / R8: fill all slots, then overflow attempt
    for (int i = 0; i < 8; i++) give(8'(8'h11 * (i + 1)));
    give(8'hEE);                       // R8: full, must be dropped
    rd_reg(8'h64, "R11 full ext status");
    rd_reg(8'h54, "R10 line status data");
    rd_reg(8'h48, "R4 id rx data");
    rd_reg(8'h00, "R3 summary rx");
    for (int i = 0; i < 8; i++) rd_reg(8'h40, "R6 pop order");
    // R7: read past empty returns slot 0 contents
    rd_reg(8'h40, "R7 stale read");
    rd_reg(8'h64, "R7 count unchanged");
    rd_reg(8'h48, "R4 id empty rx enabled");

    // R9: simultaneous receive and pop
    give(8'hA1); give(8'hA2); give(8'hA3);
    cyc(1'b1, 1'b0, 8'h40, 32'h0, 1'b1, 8'hA4, "R9 pop with push");
    rd_reg(8'h64, "R9 count kept");
    rd_reg(8'h40, "R9 order a2");
    rd_reg(8'h40, "R9 order a3");
    rd_reg(8'h40, "R9 order a4");

    // R5: flush variants
    give(8'hB1); give(8'hB2);
    wr_reg(8'h48, 32'h0000_0001, "R5 no flush bit");
    rd_reg(8'h64, "R5 count after bit0 write");
    wr_reg(8'h48, 32'h0000_0002, "R5 flush");
    rd_reg(8'h64, "R5 empty after flush");
    give(8'hB3);
    cyc(1'b1, 1'b1, 8'h48, 32'h2, 1'b1, 8'hB4, "R5 flush with push");
    rd_reg(8'h64, "R5 push discarded");
    give(8'hB5);
    rd_reg(8'h40, "R5 read position kept");

    // R12: transmit strobes, back to back
    wr_reg(8'h40, 32'h0000_01A5, "R12");
    wr_reg(8'h40, 32'h0000_005A, "R12");
    idle();
    idle();

    // R13: unknown / unimplemented offsets
    wr_reg(8'h4C, 32'hFFFF_FFFF, "R13");
    wr_reg(8'h5C, 32'hFFFF_FFFF, "R13");
    wr_reg(8'h68, 32'hFFFF_FFFF, "R13");
    wr_reg(8'h60, 32'h0, "R13");
    wr_reg(8'h04, 32'h0, "R13");
    wr_reg(8'h45, 32'h3, "R13 unaligned enable write");
    wr_reg(8'h4A, 32'h2, "R13 unaligned flush write");
    give(8'hC1);
    rd_reg(8'h4C, "R13 read zero");
    rd_reg(8'h5C, "R13 read zero");
    rd_reg(8'h68, "R13 read zero");
    rd_reg(8'h80, "R13 read zero");
    rd_reg(8'h41, "R13 unaligned read zero");
    rd_reg(8'h44, "R13 enable unchanged");
    rd_reg(8'h64, "R13 fifo unchanged");
    rd_reg(8'h60, "R10 extra control");
    rd_reg(8'h04, "R10 enables");

    // Pseudo-random mixed traffic against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[3:1])
        3'd0, 3'd1: a = 8'h40;
        3'd2: a = 8'h44;
        3'd3: a = (lfsr[7:4] == 0) ? 8'h48 : 8'h64;
        3'd4: a = 8'h00;
        3'd5: a = 8'h54;
        3'd6: a = {2'b01, lfsr[9:4]};
        default: a = 8'h40;
      endcase
      cyc(lfsr[0] | lfsr[11], lfsr[8] & lfsr[2], a, {16'd0, lfsr},
          lfsr[12] | lfsr[5], lfsr[15:8], "R6 mixed traffic");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule